// File: doc/BRIEF.md
# I/O Access Status Register

This block keeps a sticky 16-bit record of which peripheral-bus I/O strobes have carried a qualifying access. The low byte holds one flag for each output-side strobe and the high byte one flag for each input-side strobe. A flag is set by a qualifying access and stays set until the host CPU clears it. The host clears a flag by writing a one to its position, and each byte has its own byte-write strobe.

Whether an access qualifies depends on the strobe. The data-port-0 strobes also need the transfer count for their direction to be exhausted. The card-select and bus-reset strobes always qualify. Every other strobe needs the card to be selected.

The block drives a registered, single-cycle interrupt. It fires when any flag goes from 0 to 1, and also when a 3-bit bus status word (clock live, bus in reset, extended mode) differs from the value it had at the previous clock edge. Strobes arrive already synchronised and decoded, one clock domain throughout.

Top module: `ioAccessTracker`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it is released, `regRdata` is all zero and `irq` is low.
- R2: A flag that has been set keeps reading 1 on every later cycle until the host clears it; inputs sampled at a rising edge take effect on `regRdata` straight after that edge.
- R3: A host write with `hostWrEn` high clears, at that edge, each flag in bits 7:0 whose `hostWdata` bit is 1 when `hostWstrb[0]` is 1, and each flag in bits 15:8 whose `hostWdata` bit is 1 when `hostWstrb[1]` is 1. Zero data bits, and `hostWstrb[3:2]`, change nothing.
- R4: When a set and a clear reach the same flag at the same edge, the flag reads 0 afterwards, and that edge raises no interrupt for it.
- R5: Bit 0 is set by `outStrobe[0]` only while `deviceSelected` and `outDmaZero` are both 1. Bit 8 is set by `inStrobe[0]` only while `deviceSelected` and `inDmaZero` are both 1.
- R6: `cardSelStrobe` sets bit 1 and `busResetStrobe` sets bit 15 whatever the value of `deviceSelected`.
- R7: `outStrobe[k]` for k=1..4 sets bit k+1, and `inStrobe[k]` for k=1..2 sets bit 8+k, only while `deviceSelected` is 1.
- R8: Bits 7:6, 14:11 and 31:16 of `regRdata` always read 0.
- R9: `irq` is high in the cycle after an edge at which any flag went from 0 to 1. Setting a flag that is already 1 raises no interrupt.
- R10: `irq` is high in the cycle after an edge at which `busStatus` differs from its value at the previous edge. Before the first edge after reset, the previous value counts as 0.
- R11: `irq` is a registered pulse that falls after one cycle unless a new cause occurs at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| outStrobe | input | 5 | Decoded output strobes, index 0 is the data port |
| inStrobe | input | 3 | Decoded input strobes, index 0 is the data port |
| cardSelStrobe | input | 1 | Card-select strobe |
| busResetStrobe | input | 1 | Bus-reset strobe |
| deviceSelected | input | 1 | Card is currently selected |
| outDmaZero | input | 1 | Output transfer count exhausted |
| inDmaZero | input | 1 | Input transfer count exhausted |
| busStatus | input | 3 | Bus status word {extended mode, in reset, clock live} |
| hostWrEn | input | 1 | Host write to the status register |
| hostWdata | input | 32 | Host write data |
| hostWstrb | input | 4 | Host byte-write strobes |
| regRdata | output | 32 | Status register read value |
| irq | output | 1 | Interrupt pulse |

## Verification
A strobe setting a flag and a host write clearing that same flag can fall in the same cycle. The bench provokes this directly by raising the card-select strobe while writing a one to bit 1. It also lets random strobes and random clearing writes collide over thousands of cycles. A behavioural reference model is applied at every edge and judges each collision on both the flag value and the interrupt, so the clear must win and no interrupt may appear.

// File: rtl/ioat_pkg.sv
package ioat_pkg;
  localparam int FLAG_W = 16;
  localparam int OUT_BASE = 0;   // output-side byte
  localparam int IN_BASE = 8;    // input-side byte
  localparam int OUT_P0_BIT = OUT_BASE + 0;
  localparam int CARD_SEL_BIT = OUT_BASE + 1;
  localparam int OUT_PORT_FIRST = OUT_BASE + 2; // output port 1 lands here
  localparam int IN_P0_BIT = IN_BASE + 0;
  localparam int IN_PORT_FIRST = IN_BASE + 1;   // input port 1 lands here
  localparam int BUS_RST_BIT = IN_BASE + 7;

  typedef struct packed {
    logic [FLAG_W-1:0] setMask;
    logic [FLAG_W-1:0] clrMask;
  } flagCtrl_t;
endpackage

// File: rtl/ioatQualify.sv
module ioatQualify
  import ioat_pkg::*;
#(
  parameter int OUT_PORTS = 5,
  parameter int IN_PORTS = 3,
  parameter int DATA_W = 32,
  localparam int LANES = FLAG_W / 8
) (
  input  logic [OUT_PORTS-1:0] outStrobe,
  input  logic [IN_PORTS-1:0]  inStrobe,
  input  logic                 cardSelStrobe,
  input  logic                 busResetStrobe,
  input  logic                 deviceSelected,
  input  logic                 outDmaZero,
  input  logic                 inDmaZero,
  input  logic                 hostWrEn,
  input  logic [DATA_W-1:0]    hostWdata,
  input  logic [DATA_W/8-1:0]  hostWstrb,
  output flagCtrl_t            ctrl
);
  logic [OUT_PORTS-1:0] outQual;
  logic [IN_PORTS-1:0]  inQual;
  logic [FLAG_W-1:0]    laneClr;

  // Data port 0 additionally waits for an exhausted transfer count.
  assign outQual[0] = outStrobe[0] & deviceSelected & outDmaZero;
  assign inQual[0]  = inStrobe[0] & deviceSelected & inDmaZero;

  genvar k;
  generate
    for (k = 1; k < OUT_PORTS; k++) begin : gOutPort
      assign outQual[k] = outStrobe[k] & deviceSelected;
    end
    for (k = 1; k < IN_PORTS; k++) begin : gInPort
      assign inQual[k] = inStrobe[k] & deviceSelected;
    end
    for (k = 0; k < LANES; k++) begin : gLane
      assign laneClr[k*8 +: 8] = (hostWrEn & hostWstrb[k]) ? hostWdata[k*8 +: 8] : 8'h00;
    end
  endgenerate

  always_comb begin
    ctrl = '0;
    ctrl.setMask[OUT_P0_BIT]   = outQual[0];
    ctrl.setMask[CARD_SEL_BIT] = cardSelStrobe;
    for (int i = 1; i < OUT_PORTS; i++)
      ctrl.setMask[OUT_PORT_FIRST + i - 1] = outQual[i];
    ctrl.setMask[IN_P0_BIT]   = inQual[0];
    for (int i = 1; i < IN_PORTS; i++)
      ctrl.setMask[IN_PORT_FIRST + i - 1] = inQual[i];
    ctrl.setMask[BUS_RST_BIT] = busResetStrobe;
    ctrl.clrMask = laneClr;
  end
endmodule

// File: rtl/ioatFlags.sv
module ioatFlags
  import ioat_pkg::*;
#(
  parameter int STATUS_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  flagCtrl_t           ctrl,
  input  logic [STATUS_W-1:0] busStatus,
  output logic [FLAG_W-1:0]   flags,
  output logic                irq
);
  logic [FLAG_W-1:0]   flagsNext;
  logic [FLAG_W-1:0]   riseMask;
  logic [STATUS_W-1:0] statusPrev;
  logic                statusMoved;

  // Clear dominates a simultaneous set.
  assign flagsNext   = (flags | ctrl.setMask) & ~ctrl.clrMask;
  assign riseMask    = flagsNext & ~flags;
  assign statusMoved = (busStatus != statusPrev);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags      <= '0;
      statusPrev <= '0;
      irq        <= 1'b0;
    end else begin
      flags      <= flagsNext;
      statusPrev <= busStatus;
      irq        <= (|riseMask) | statusMoved;
    end
  end
endmodule

// File: rtl/ioAccessTracker.sv
module ioAccessTracker
  import ioat_pkg::*;
#(
  parameter int OUT_PORTS = 5,
  parameter int IN_PORTS = 3,
  parameter int STATUS_W = 3,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [OUT_PORTS-1:0] outStrobe,
  input  logic [IN_PORTS-1:0] inStrobe,
  input  logic                cardSelStrobe,
  input  logic                busResetStrobe,
  input  logic                deviceSelected,
  input  logic                outDmaZero,
  input  logic                inDmaZero,
  input  logic [STATUS_W-1:0] busStatus,
  input  logic                hostWrEn,
  input  logic [DATA_W-1:0]   hostWdata,
  input  logic [DATA_W/8-1:0] hostWstrb,
  output logic [DATA_W-1:0]   regRdata,
  output logic                irq
);
  flagCtrl_t         ctrl;
  logic [FLAG_W-1:0] flags;

  ioatQualify #(
    .OUT_PORTS(OUT_PORTS), .IN_PORTS(IN_PORTS), .DATA_W(DATA_W)
  ) i_qualify (
    .outStrobe(outStrobe), .inStrobe(inStrobe),
    .cardSelStrobe(cardSelStrobe), .busResetStrobe(busResetStrobe),
    .deviceSelected(deviceSelected), .outDmaZero(outDmaZero),
    .inDmaZero(inDmaZero), .hostWrEn(hostWrEn),
    .hostWdata(hostWdata), .hostWstrb(hostWstrb), .ctrl(ctrl)
  );

  ioatFlags #(.STATUS_W(STATUS_W)) i_flags (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .busStatus(busStatus),
    .flags(flags), .irq(irq)
  );

  assign regRdata = {{(DATA_W-FLAG_W){1'b0}}, flags};
endmodule

// File: rtl/ioatChecker.sv
module ioatChecker (
  input logic        clk,
  input logic        rstN,
  input logic        cardSelStrobe,
  input logic        busResetStrobe,
  input logic        hostWrEn,
  input logic [31:0] hostWdata,
  input logic [3:0]  hostWstrb,
  input logic [31:0] regRdata,
  input logic        irq
);
  // R3 and R4: a written one leaves the flag clear, set or not.
  assert_clrLow_R3: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostWstrb[0]) |=> ((regRdata[7:0] & $past(hostWdata[7:0])) == 8'h00));
  assert_clrHigh_R4: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostWstrb[1]) |=> ((regRdata[15:8] & $past(hostWdata[15:8])) == 8'h00));
  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    !hostWrEn |=> (($past(regRdata[15:0]) & ~regRdata[15:0]) == 16'h0000));
  assert_cardSel_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cardSelStrobe && !(hostWrEn && hostWstrb[0] && hostWdata[1])) |=> regRdata[1]);
  assert_busReset_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busResetStrobe && !(hostWrEn && hostWstrb[1] && hostWdata[15])) |=> regRdata[15]);
  assert_unused_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regRdata[31:16] == 16'h0) && (regRdata[7:6] == 2'b00) && (regRdata[14:11] == 4'h0));
  assert_riseIrq_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((regRdata[15:0] & ~$past(regRdata[15:0])) != 16'h0) |-> irq);
endmodule

bind ioAccessTracker ioatChecker i_ioatChecker (
  .clk(clk), .rstN(rstN), .cardSelStrobe(cardSelStrobe),
  .busResetStrobe(busResetStrobe), .hostWrEn(hostWrEn),
  .hostWdata(hostWdata), .hostWstrb(hostWstrb),
  .regRdata(regRdata), .irq(irq)
);

// File: tb/test_ioAccessTracker.sv
`timescale 1ns/1ps
module test_ioAccessTracker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  outStrobe;
  logic [2:0]  inStrobe;
  logic        cardSelStrobe, busResetStrobe, deviceSelected;
  logic        outDmaZero, inDmaZero, hostWrEn;
  logic [2:0]  busStatus;
  logic [31:0] hostWdata;
  logic [3:0]  hostWstrb;
  logic [31:0] regRdata;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // behavioural reference state
  logic [15:0] mFlags = '0;
  logic        mIrq = 1'b0;
  logic [2:0]  mStat = '0;

  always #4 clk = ~clk;

  ioAccessTracker i_ioAccessTracker (
    .clk(clk), .rstN(rstN), .outStrobe(outStrobe), .inStrobe(inStrobe),
    .cardSelStrobe(cardSelStrobe), .busResetStrobe(busResetStrobe),
    .deviceSelected(deviceSelected), .outDmaZero(outDmaZero),
    .inDmaZero(inDmaZero), .busStatus(busStatus), .hostWrEn(hostWrEn),
    .hostWdata(hostWdata), .hostWstrb(hostWstrb),
    .regRdata(regRdata), .irq(irq)
  );

  task automatic quiet();
    outStrobe = '0; inStrobe = '0; cardSelStrobe = 0; busResetStrobe = 0;
    deviceSelected = 0; outDmaZero = 0; inDmaZero = 0; hostWrEn = 0;
    hostWdata = '0; hostWstrb = '0;
  endtask

  task automatic modelStep();
    logic [15:0] setV, clrV, nxt;
    setV = '0;
    if (deviceSelected && outDmaZero && outStrobe[0]) setV[0] = 1;
    if (cardSelStrobe) setV[1] = 1;
    for (int k = 1; k <= 4; k++) if (deviceSelected && outStrobe[k]) setV[k+1] = 1;
    if (deviceSelected && inDmaZero && inStrobe[0]) setV[8] = 1;
    for (int k = 1; k <= 2; k++) if (deviceSelected && inStrobe[k]) setV[8+k] = 1;
    if (busResetStrobe) setV[15] = 1;
    clrV = '0;
    if (hostWrEn && hostWstrb[0]) clrV[7:0] = hostWdata[7:0];
    if (hostWrEn && hostWstrb[1]) clrV[15:8] = hostWdata[15:8];
    nxt = (mFlags | setV) & ~clrV;
    mIrq = ((nxt & ~mFlags) != 0) || (busStatus != mStat);
    mStat = busStatus;
    mFlags = nxt;
  endtask

  task automatic compare(input string tag);
    checks++;
    if (regRdata !== {16'h0, mFlags}) begin
      fails++;
      $display("FAIL %s regRdata actual=%h expected=%h", tag, regRdata, {16'h0, mFlags});
    end
    checks++;
    if (irq !== mIrq) begin
      fails++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, mIrq);
    end
  endtask

  // Inputs are set at the falling edge; the clock edge applies them.
  task automatic tick(input string tag);
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    quiet();
    busStatus = '0;
    repeat (3) @(negedge clk);
    compare("R1");
    rstN = 1'b1;
    tick("R1");

    // R7: other strobes ignored while not selected
    outStrobe = 5'b11110; inStrobe = 3'b110;
    tick("R7");
    quiet();

    // R5: data port 0 needs exhausted count
    deviceSelected = 1; outStrobe = 5'b00001; inStrobe = 3'b001;
    tick("R5");
    outDmaZero = 1;
    tick("R5");
    inDmaZero = 1;
    tick("R5");
    quiet();
    tick("R11");

    // R6: always valid strobes
    cardSelStrobe = 1; busResetStrobe = 1;
    tick("R6");
    quiet();

    // R7: selected strobes
    deviceSelected = 1; outStrobe = 5'b11110; inStrobe = 3'b110;
    tick("R7");
    // R9: re-setting set flags raises nothing
    tick("R9");
    quiet();

    // R8: every strobe at once
    deviceSelected = 1; outDmaZero = 1; inDmaZero = 1;
    outStrobe = '1; inStrobe = '1; cardSelStrobe = 1; busResetStrobe = 1;
    tick("R8");
    quiet();

    // R3: byte-lane write-one-to-clear
    hostWrEn = 1; hostWstrb = 4'b0001; hostWdata = 32'h0000_FF03;
    tick("R3");
    hostWstrb = 4'b1100; hostWdata = 32'hFFFF_FFFF;
    tick("R3");
    hostWstrb = 4'b0010; hostWdata = 32'h0000_8100;
    tick("R3");
    hostWstrb = 4'b0011; hostWdata = 32'h0000_0000;
    tick("R3");
    quiet();

    // R4: set and clear of bit 1 at the same edge
    cardSelStrobe = 1; hostWrEn = 1; hostWstrb = 4'b0001; hostWdata = 32'h2;
    tick("R4");
    quiet();
    tick("R4");

    // R10: status word change
    busStatus = 3'b101;
    tick("R10");
    tick("R10");
    busStatus = 3'b100;
    tick("R10");
    tick("R11");

    // R2: random traffic with colliding sets and clears
    for (int n = 0; n < 3000; n++) begin
      outStrobe = 5'($urandom); inStrobe = 3'($urandom);
      cardSelStrobe = ($urandom % 8) == 0; busResetStrobe = ($urandom % 16) == 0;
      deviceSelected = $urandom % 2; outDmaZero = $urandom % 2; inDmaZero = $urandom % 2;
      busStatus = (($urandom % 10) == 0) ? 3'($urandom) : busStatus;
      hostWrEn = ($urandom % 4) == 0; hostWstrb = 4'($urandom); hostWdata = $urandom;
      tick("R2");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule